// File: doc/BRIEF.md
# Address Map Region Decoder

This combinational block sits between the processor address bus and the memory devices. For each 16-bit address it decides which single source answers the access. The candidates are a small register window, the I/O space, system ROM, internal function ROM, external function ROM and RAM. When RAM is chosen, the block also reports which RAM bank to use.

The active configuration word sets the source for each 16 KB region. Bits 7:6 hold the RAM bank, bits 5:4 the high-region code, bits 3:2 the mid-region code, bit 1 the low-region bit and bit 0 the character-window bit. Two RAM-sharing controls add a common area at the bottom and/or the top of memory, with a programmable size. RAM accesses that fall inside an enabled common area always go to bank 0.

Top module: `addr_map_decoder`

## Requirements
- R1: `selOut` is one-hot for every input combination. Bit 0 is the register window, 1 is I/O, 2 is system ROM, 3 is internal function ROM, 4 is external function ROM and 5 is RAM.
- R2: Addresses 0xFF00 through 0xFF04 select the register window under every configuration. Address 0xFF05 is decoded by its region code like any other address.
- R3: In 0xD000–0xDFFF with `cfgWord[0]` = 0, I/O is selected.
- R4: In 0xD000–0xDFFF with `cfgWord[0]` = 1, the selection follows the high-region code.
- R5: In 0xC000–0xFFFF, outside the register window and I/O, `cfgWord[5:4]` picks the source: 00 system ROM, 01 internal function ROM, 10 external function ROM, 11 RAM.
- R6: In 0x8000–0xBFFF, `cfgWord[3:2]` picks the source with the same encoding as R5.
- R7: In 0x4000–0x7FFF, `cfgWord[1]` = 0 selects system ROM and 1 selects RAM.
- R8: Addresses 0x0000–0x3FFF always select RAM.
- R9: `shareSize` sets the common-area size: 00 is 1 KB, 01 is 4 KB, 10 is 8 KB, 11 is 16 KB. With `shareBottom` = 1, RAM accesses below that size use bank 0. With `shareTop` = 1, RAM accesses within that size of 0xFFFF use bank 0.
- R10: A RAM access outside every enabled common area uses bank `cfgWord[7:6]`. When RAM is not selected, `ramBank` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address |
| cfgWord | input | 8 | Active configuration word |
| shareSize | input | 2 | Common RAM size code |
| shareBottom | input | 1 | Enable common area at the bottom of memory |
| shareTop | input | 1 | Enable common area at the top of memory |
| selOut | output | 6 | One-hot source select |
| ramBank | output | 2 | RAM bank for the access |

## Verification
Random addresses, configuration words and sharing settings are compared against a reference function. This exercises every region code together with every combination of common-area size and enable.

Directed vectors probe the edges where one decision hands over to the next:
- the last register-window address against the first ordinary one;
- the character-window bit on either side of the I/O range;
- the first and last byte of each common-area size, telling bank 0 apart from the configured bank.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  typedef enum logic [1:0] {RGN_FIX, RGN_LOW, RGN_MID, RGN_HIGH} region_e;

  typedef struct packed {
    logic    regHit;
    logic    ioHit;
    logic    sharedHit;
    region_e region;
  } dec_strobe_t;

  localparam int SEL_W   = 6;
  localparam int SEL_REG = 0;
  localparam int SEL_IO  = 1;
  localparam int SEL_SRC = 2;  // sources 2..5 follow the 2-bit code order
  localparam int SEL_RAM = 5;
  localparam logic [1:0] CODE_RAM = 2'b11;
  localparam logic [1:0] CODE_SYS = 2'b00;
endpackage

// File: rtl/addr_dec_ctrl.sv
module addr_dec_ctrl
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int REG_BASE  = 'hFF00,
  parameter int REG_COUNT = 5,
  parameter logic [3:0] IO_NIBBLE = 4'hD
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              charSel,
  input  logic [1:0]        shareSize,
  input  logic              shareBottom,
  input  logic              shareTop,
  output dec_strobe_t       strb
);
  localparam logic [ADDR_W:0] REG_LO   = REG_BASE[ADDR_W:0];
  localparam logic [ADDR_W:0] REG_HI   = REG_LO + REG_COUNT[ADDR_W:0];
  localparam logic [ADDR_W:0] SPACE_SZ = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0] wideAddr;
  logic [ADDR_W:0] shareLen;
  logic            inBottom;
  logic            inTop;

  assign wideAddr = {1'b0, addr};

  always_comb begin
    unique case (shareSize)
      2'b00:   shareLen = (ADDR_W+1)'(1) << 10;
      2'b01:   shareLen = (ADDR_W+1)'(1) << 12;
      2'b10:   shareLen = (ADDR_W+1)'(1) << 13;
      default: shareLen = (ADDR_W+1)'(1) << 14;
    endcase
  end

  assign inBottom = shareBottom && (wideAddr < shareLen);
  assign inTop    = shareTop && (wideAddr >= (SPACE_SZ - shareLen));

  always_comb begin
    strb.regHit    = (wideAddr >= REG_LO) && (wideAddr < REG_HI);
    strb.ioHit     = (addr[ADDR_W-1 -: 4] == IO_NIBBLE) && !charSel;
    strb.sharedHit = inBottom || inTop;
    strb.region    = region_e'(addr[ADDR_W-1 -: 2]);
  end
endmodule

// File: rtl/addr_dec_dp.sv
module addr_dec_dp
  import addr_dec_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int BANK_W = 2
) (
  input  dec_strobe_t       strb,
  input  logic [CFG_W-1:0]  cfgWord,
  output logic [SEL_W-1:0]  selOut,
  output logic [BANK_W-1:0] ramBank
);
  logic [1:0] srcCode;
  logic       plainPath;

  always_comb begin
    unique case (strb.region)
      RGN_FIX:  srcCode = CODE_RAM;
      RGN_LOW:  srcCode = cfgWord[1] ? CODE_RAM : CODE_SYS;
      RGN_MID:  srcCode = cfgWord[3:2];
      default:  srcCode = cfgWord[5:4];
    endcase
  end

  assign plainPath      = !strb.regHit && !strb.ioHit;
  assign selOut[SEL_REG] = strb.regHit;
  assign selOut[SEL_IO]  = !strb.regHit && strb.ioHit;

  generate
    for (genvar i = 0; i < 4; i++) begin : g_src
      assign selOut[SEL_SRC+i] = plainPath && (srcCode == 2'(i));
    end
  endgenerate

  assign ramBank = (selOut[SEL_RAM] && !strb.sharedHit)
                   ? cfgWord[CFG_W-1 -: BANK_W] : '0;
endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
  import addr_dec_pkg::*;
(
  input  logic [15:0] addr,
  input  logic [7:0]  cfgWord,
  input  logic [1:0]  shareSize,
  input  logic        shareBottom,
  input  logic        shareTop,
  output logic [5:0]  selOut,
  output logic [1:0]  ramBank
);
  dec_strobe_t strb;

  addr_dec_ctrl #(.ADDR_W(16)) u_ctrl (
    .addr        (addr),
    .charSel     (cfgWord[0]),
    .shareSize   (shareSize),
    .shareBottom (shareBottom),
    .shareTop    (shareTop),
    .strb        (strb)
  );

  addr_dec_dp #(.CFG_W(8), .BANK_W(2)) u_dp (
    .strb    (strb),
    .cfgWord (cfgWord),
    .selOut  (selOut),
    .ramBank (ramBank)
  );
endmodule

// File: rtl/addr_map_decoder_chk.sv
module addr_map_decoder_chk (
  input logic [15:0] addr,
  input logic [7:0]  cfgWord,
  input logic [1:0]  shareSize,
  input logic        shareBottom,
  input logic        shareTop,
  input logic [5:0]  selOut,
  input logic [1:0]  ramBank
);
  logic known;
  assign known = !$isunknown({addr, cfgWord, shareSize, shareBottom, shareTop});

  always_comb begin
    if (known) begin
      AST_ONE_HOT: assert ($onehot(selOut)) else $error("one-hot select broken"); // R1
      AST_REG_WINDOW: assert (!(addr >= 16'hFF00 && addr <= 16'hFF04) || selOut == 6'b000001)
        else $error("register window missed"); // R2
      AST_IO_WINDOW: assert (!(addr[15:12] == 4'hD && !cfgWord[0]) || selOut == 6'b000010)
        else $error("I/O window missed"); // R3
      AST_LOW_RAM: assert (addr >= 16'h4000 || selOut == 6'b100000)
        else $error("bottom region not RAM"); // R8
      AST_BANK_IDLE: assert (selOut[5] || ramBank == 2'b00)
        else $error("bank without RAM select"); // R10
      AST_SHARED_BOTTOM: assert (!(shareBottom && addr < 16'h0400) || ramBank == 2'b00)
        else $error("shared bottom not bank 0"); // R9
    end
  end
endmodule

bind addr_map_decoder addr_map_decoder_chk u_chk (
  .addr(addr), .cfgWord(cfgWord), .shareSize(shareSize),
  .shareBottom(shareBottom), .shareTop(shareTop),
  .selOut(selOut), .ramBank(ramBank)
);

// File: tb/addr_map_decoder_tb.sv
module addr_map_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] addr = '0;
  logic [7:0]  cfgWord = '0;
  logic [1:0]  shareSize = '0;
  logic        shareBottom = 1'b0;
  logic        shareTop = 1'b0;
  logic [5:0]  selOut;
  logic [1:0]  ramBank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  addr_map_decoder u_dut (
    .addr(addr), .cfgWord(cfgWord), .shareSize(shareSize),
    .shareBottom(shareBottom), .shareTop(shareTop),
    .selOut(selOut), .ramBank(ramBank)
  );

  function automatic int shareBytes(logic [1:0] s);
    case (s)
      2'b00:   return 1024;
      2'b01:   return 4096;
      2'b10:   return 8192;
      default: return 16384;
    endcase
  endfunction

  // returns {bank, sel}
  function automatic logic [7:0] refModel(logic [15:0] a, logic [7:0] c, logic [1:0] s,
                                          logic b, logic t);
    logic [5:0] sel;
    logic [1:0] code;
    logic [1:0] bank;
    int len = shareBytes(s);
    bit shared = (b && int'(a) < len) || (t && int'(a) >= 65536 - len);
    if (a >= 16'hFF00 && a <= 16'hFF04) sel = 6'b000001;
    else if (a[15:12] == 4'hD && !c[0]) sel = 6'b000010;
    else begin
      if (a < 16'h4000) code = 2'b11;
      else if (a < 16'h8000) code = c[1] ? 2'b11 : 2'b00;
      else if (a < 16'hC000) code = c[3:2];
      else code = c[5:4];
      sel = 6'b000100 << code;
    end
    bank = (sel[5] && !shared) ? c[7:6] : 2'b00;
    return {bank, sel};
  endfunction

  function automatic string tagOf(logic [15:0] a, logic [7:0] c);
    if (a >= 16'hFF00 && a <= 16'hFF04) return "R2";
    if (a[15:12] == 4'hD) return c[0] ? "R4" : "R3";
    if (a < 16'h4000) return "R8";
    if (a < 16'h8000) return "R7";
    if (a < 16'hC000) return "R6";
    return "R5";
  endfunction

  task automatic applyCheck(logic [15:0] a, logic [7:0] c, logic [1:0] s,
                            logic b, logic t, string tag);
    logic [7:0] exp;
    @(posedge clk);
    addr = a; cfgWord = c; shareSize = s; shareBottom = b; shareTop = t;
    @(negedge clk);
    exp = refModel(a, c, s, b, t);
    checks++;
    if (selOut !== exp[5:0]) begin
      errors++;
      $display("FAIL %s addr=%h cfg=%h sel actual=%b expected=%b", tag, a, c, selOut, exp[5:0]);
    end
    checks++;
    if (ramBank !== exp[7:6]) begin
      errors++;
      $display("FAIL %s/R10 addr=%h cfg=%h bank actual=%0d expected=%0d", tag, a, c, ramBank, exp[7:6]);
    end
    checks++;
    if (!$onehot(selOut)) begin  // R1
      errors++;
      $display("FAIL R1 addr=%h sel actual=%b expected one-hot", a, selOut);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs give RAM bank 0 (R8)
    applyCheck(16'h0000, 8'h00, 2'b00, 1'b0, 1'b0, "R8");
    // R2 register window under an all-RAM config, and the first address beyond it
    for (int i = 0; i < 5; i++) applyCheck(16'hFF00 + 16'(i), 8'hFF, 2'b11, 1'b1, 1'b1, "R2");
    applyCheck(16'hFF05, 8'h3F, 2'b00, 1'b0, 1'b0, "R2");
    applyCheck(16'hFF05, 8'h00, 2'b00, 1'b0, 1'b0, "R2");
    // R3 / R4 character window
    applyCheck(16'hD000, 8'hF0, 2'b00, 1'b0, 1'b0, "R3");
    applyCheck(16'hDFFF, 8'hF0, 2'b00, 1'b0, 1'b0, "R3");
    applyCheck(16'hD000, 8'h11, 2'b00, 1'b0, 1'b0, "R4");
    applyCheck(16'hCFFF, 8'h20, 2'b00, 1'b0, 1'b0, "R5");
    applyCheck(16'hE000, 8'hB1, 2'b00, 1'b0, 1'b0, "R5");
    // R6 / R7 every code
    for (int k = 0; k < 4; k++) applyCheck(16'h9000, 8'h80 | 8'(k << 2), 2'b00, 1'b0, 1'b0, "R6");
    applyCheck(16'h4000, 8'h40, 2'b00, 1'b0, 1'b0, "R7");
    applyCheck(16'h7FFF, 8'h42, 2'b00, 1'b0, 1'b0, "R7");
    // R9 common-area edges for every size
    for (int s = 0; s < 4; s++) begin
      int len = shareBytes(2'(s));
      applyCheck(16'(len - 1), 8'hFE, 2'(s), 1'b1, 1'b0, "R9");
      applyCheck(16'(len),     8'hFE, 2'(s), 1'b1, 1'b0, "R9");
      applyCheck(16'(65536 - len),     8'hFE, 2'(s), 1'b0, 1'b1, "R9");
      applyCheck(16'(65535 - len),     8'hFE, 2'(s), 1'b0, 1'b1, "R9");
    end
    applyCheck(16'h0010, 8'hC0, 2'b11, 1'b0, 1'b1, "R10");
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a = 16'($urandom);
      logic [7:0]  c = 8'($urandom);
      if (n % 5 == 0) a = 16'hFF00 + 16'($urandom_range(0, 7));
      applyCheck(a, c, 2'($urandom), 1'($urandom), 1'($urandom), tagOf(a, c));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule